// File: doc/BRIEF.md
# PCI Configuration Cycle Router

This block sits on the processor's I/O path. It turns the two-port indirect configuration scheme into routed configuration requests. Software first writes a 32-bit configuration address to the address port at I/O 0xCF8. That value holds an enable flag, a bus number, a device number, a function number and a doubleword index. Every later access to the data port at 0xCFC..0xCFF is then translated into one configuration request that targets the place the held address decodes to.

There are four destinations:
- the internal host-to-link bridge registers, hardwired as bus 0 device 0;
- the internal host-to-PCI-Express bridge registers, hardwired as bus 0 device 1;
- the downstream PCI Express port, which owns the bus window set by that bridge's programmable secondary and subordinate bus numbers;
- the chip-to-chip link, which takes the remaining bus-0 devices as Type 0 cycles and every other bus as Type 1 cycles.

The block issues a one-cycle request carrying:
- the target select;
- a Type 0 or Type 1 flag;
- the translated address;
- the access direction, byte enables and write data.

It then waits for the responder's completion and passes it back to the I/O side. When the enable flag is clear, no request is issued. A read then returns all ones and a write is dropped.

Top module: `cfg_cycle_router`

## Requirements
- R1: The address register resets to zero. A write at the address port with all four byte enables set stores the write data with bits 1:0 forced to 0. A read at the address port returns the stored value. Each address-port access completes with `io_done` high for one cycle, in the cycle after the access is sampled.
- R2: An address-port write with any byte enable clear still completes, but leaves the stored address unchanged.
- R3: With bit 31 of the address register clear, a data-port access issues no request. It completes in the cycle after it is sampled, and a read returns 0xFFFFFFFF.
- R4: With bit 31 set, bus number (bits 23:16) 0 and device number (bits 15:11) 0, the request has target 0 (host-to-link bridge registers) and Type 0. Device 1 on bus 0 gives target 1 (host-to-PCI-Express bridge registers) and Type 0.
- R5: With bit 31 set, bus 0 and a device number other than 0 or 1, the request has target 3 (chip-to-chip link) and Type 0.
- R6: A non-zero bus number with `sec_bus` <= bus <= `sub_bus` gives target 2 (PCI Express port). The cycle is Type 0 when the bus equals `sec_bus`, and Type 1 otherwise.
- R7: A non-zero bus number outside that window gives target 3 with Type 1. If `sec_bus` > `sub_bus`, the window is empty.
- R8: `req_addr` has bits 31:24 zero and bits 23:2 copied from the address register. Bits 1:0 are 01 for Type 1 and 00 for Type 0. `req_write`, `req_be` and `req_wdata` repeat the data-port access.
- R9: `req_valid` is a one-cycle pulse in the cycle after the data-port access is sampled. `io_done` rises in the cycle after `rsp_valid` is sampled. For reads, `io_rdata` then equals `rsp_rdata`.
- R10: An I/O access to any other port gives no completion and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | Processor I/O access strobe, one cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | IOW | I/O byte address |
| io_be | input | 4 | Byte enables |
| io_wdata | input | 32 | Write data |
| io_done | output | 1 | Completion pulse |
| io_rdata | output | 32 | Read data, valid with io_done |
| sec_bus | input | 8 | Secondary bus number of the PCI Express bridge |
| sub_bus | input | 8 | Subordinate bus number of the PCI Express bridge |
| req_valid | output | 1 | Configuration request pulse |
| req_target | output | 2 | 0 link-bridge regs, 1 PCIe-bridge regs, 2 PCIe port, 3 link |
| req_type1 | output | 1 | 1 = Type 1 cycle |
| req_addr | output | 32 | Translated configuration address |
| req_write | output | 1 | Request direction |
| req_be | output | 4 | Request byte enables |
| req_wdata | output | 32 | Request write data |
| rsp_valid | input | 1 | Responder completion |
| rsp_rdata | input | 32 | Responder read data |

## Verification
Each result has a fixed arrival time:
- An address-port access, or a disabled data-port access, completes exactly one cycle after the edge that samples it.
- An enabled data-port access raises its request exactly one cycle after that edge.
- The completion follows one cycle after the edge that samples the response.

The bench drives every input on a falling edge. It samples on the falling edge that follows exactly that many rising edges, and it also confirms that nothing shows up in the gaps. The response delay is drawn at random, so the completion check tracks the chosen delay rather than a fixed window.

// File: rtl/cfg_cycle_router.sv
module cfg_cycle_router #(
  parameter int IOW = 16,
  parameter logic [IOW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IOW-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           io_valid,
  input  logic           io_write,
  input  logic [IOW-1:0] io_addr,
  input  logic [3:0]     io_be,
  input  logic [31:0]    io_wdata,
  output logic           io_done,
  output logic [31:0]    io_rdata,
  input  logic [7:0]     sec_bus,
  input  logic [7:0]     sub_bus,
  output logic           req_valid,
  output logic [1:0]     req_target,
  output logic           req_type1,
  output logic [31:0]    req_addr,
  output logic           req_write,
  output logic [3:0]     req_be,
  output logic [31:0]    req_wdata,
  input  logic           rsp_valid,
  input  logic [31:0]    rsp_rdata
);
  localparam logic [1:0] TGT_LINKREG = 2'd0;
  localparam logic [1:0] TGT_PEREG   = 2'd1;
  localparam logic [1:0] TGT_PEPORT  = 2'd2;
  localparam logic [1:0] TGT_LINK    = 2'd3;

  logic [31:0] cfg_addr;
  logic        busy;
  logic [1:0]  tgt;
  logic        t1;

  wire       hit_addr = io_valid && !busy && (io_addr[IOW-1:2] == ADDR_PORT[IOW-1:2]);
  wire       hit_data = io_valid && !busy && (io_addr[IOW-1:2] == DATA_PORT[IOW-1:2]);
  wire [7:0] bus      = cfg_addr[23:16];
  wire [4:0] dev      = cfg_addr[15:11];
  wire       in_win   = (bus != 8'd0) && (sec_bus <= sub_bus) &&
                        (bus >= sec_bus) && (bus <= sub_bus);

  always_comb begin
    tgt = TGT_LINK;
    t1  = 1'b1;
    if (bus == 8'd0) begin
      t1 = 1'b0;
      if (dev == 5'd0)      tgt = TGT_LINKREG;
      else if (dev == 5'd1) tgt = TGT_PEREG;
    end else if (in_win) begin
      tgt = TGT_PEPORT;
      t1  = (bus != sec_bus);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_addr   <= '0;
      busy       <= 1'b0;
      io_done    <= 1'b0;
      io_rdata   <= '0;
      req_valid  <= 1'b0;
      req_target <= '0;
      req_type1  <= 1'b0;
      req_addr   <= '0;
      req_write  <= 1'b0;
      req_be     <= '0;
      req_wdata  <= '0;
    end else begin
      io_done   <= 1'b0;
      req_valid <= 1'b0;
      if (hit_addr) begin
        if (io_write && io_be == 4'hF) cfg_addr <= {io_wdata[31:2], 2'b00};
        io_done  <= 1'b1;
        io_rdata <= io_write ? 32'd0 : cfg_addr;
      end else if (hit_data) begin
        if (!cfg_addr[31]) begin
          io_done  <= 1'b1;
          io_rdata <= io_write ? 32'd0 : 32'hFFFF_FFFF;
        end else begin
          busy       <= 1'b1;
          req_valid  <= 1'b1;
          req_target <= tgt;
          req_type1  <= t1;
          req_addr   <= {8'd0, cfg_addr[23:2], 1'b0, t1};
          req_write  <= io_write;
          req_be     <= io_be;
          req_wdata  <= io_wdata;
        end
      end else if (busy && rsp_valid) begin
        busy     <= 1'b0;
        io_done  <= 1'b1;
        io_rdata <= req_write ? 32'd0 : rsp_rdata;
      end
    end
  end

  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  assert_done_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_done && req_valid));
  assert_internal_bus0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_target == TGT_LINKREG || req_target == TGT_PEREG))
      |-> (req_addr[23:16] == 8'd0 && !req_type1));
  assert_type1_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type1) |-> (req_addr[23:16] != 8'd0));
  assert_port_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_target == TGT_PEPORT) |-> (req_addr[23:16] != 8'd0));
  assert_hold_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |=> !io_done);
endmodule

// File: tb/test_cfg_cycle_router.sv
module test_cfg_cycle_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0, io_write = 1'b0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic        io_done;
  logic [31:0] io_rdata;
  logic [7:0]  sec_bus = 8'd0, sub_bus = 8'd0;
  logic        req_valid, req_type1, req_write;
  logic [1:0]  req_target;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_be;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;

  int checks = 0, errors = 0;
  logic [31:0] shadow;

  always #4 clk = ~clk;

  cfg_cycle_router i_cfg_cycle_router (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata), .io_done(io_done),
    .io_rdata(io_rdata), .sec_bus(sec_bus), .sub_bus(sub_bus),
    .req_valid(req_valid), .req_target(req_target), .req_type1(req_type1),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_route(input logic [7:0] b, input logic [4:0] d,
                                           input logic [7:0] s, input logic [7:0] u);
    if (b == 0) return (d == 0) ? 3'b000 : (d == 1) ? 3'b010 : 3'b110;
    if (s <= u && b >= s && b <= u) return {2'd2, b != s};
    return 3'b111;
  endfunction

  task automatic io_start(input bit wr, input logic [15:0] a, input logic [3:0] be, input logic [31:0] wd);
    io_valid = 1'b1; io_write = wr; io_addr = a; io_be = be; io_wdata = wd;
    @(posedge clk); @(negedge clk);
    io_valid = 1'b0;
  endtask

  task automatic addr_access(input bit wr, input logic [3:0] be, input logic [31:0] wd, input string tag);
    logic [31:0] prev = shadow;
    io_start(wr, 16'h0CF8, be, wd);
    chk(io_done === 1'b1 && req_valid === 1'b0, tag, {31'd0, io_done}, 32'd1);
    if (wr && be == 4'hF) shadow = {wd[31:2], 2'b00};
    if (!wr) chk(io_rdata === prev, tag, io_rdata, prev);
  endtask

  task automatic set_addr(input logic [31:0] v);
    addr_access(1'b1, 4'hF, v, "R1 addr write");
  endtask

  task automatic data_access(input bit wr, input logic [3:0] be, input logic [31:0] wd,
                             input logic [31:0] rd, input int dly);
    logic [2:0] r;
    logic [31:0] ea;
    r  = exp_route(shadow[23:16], shadow[15:11], sec_bus, sub_bus);
    ea = {8'd0, shadow[23:2], 1'b0, r[0]};
    io_start(wr, 16'h0CFC + 16'(dly % 4), be, wd);
    if (!shadow[31]) begin
      chk(io_done === 1'b1 && req_valid === 1'b0, "R3 disabled completes, no request", {30'd0, req_valid, io_done}, 32'd1);
      if (!wr) chk(io_rdata === 32'hFFFF_FFFF, "R3 disabled read all ones", io_rdata, 32'hFFFF_FFFF);
      return;
    end
    chk(req_valid === 1'b1 && io_done === 1'b0, "R9 request one cycle after access", {31'd0, req_valid}, 32'd1);
    if (shadow[23:16] == 0 && shadow[15:11] < 2)
      chk(req_target === r[2:1] && !req_type1, "R4 bus0 internal target", {29'd0, req_target, req_type1}, {29'd0, r});
    else if (shadow[23:16] == 0)
      chk(req_target === r[2:1] && !req_type1, "R5 bus0 other device to link", {29'd0, req_target, req_type1}, {29'd0, r});
    else if (r[2:1] == 2'd2)
      chk(req_target === 2'd2 && req_type1 === r[0], "R6 window to port", {29'd0, req_target, req_type1}, {29'd0, r});
    else
      chk(req_target === 2'd3 && req_type1 === 1'b1, "R7 outside window to link type1", {29'd0, req_target, req_type1}, {29'd0, r});
    chk(req_addr === ea, "R8 translated address", req_addr, ea);
    chk(req_write === wr && req_be === be && (!wr || req_wdata === wd), "R8 request copies access",
        {27'd0, req_write, req_be}, {27'd0, wr, be});
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(req_valid === 1'b0 && io_done === 1'b0, "R9 quiet while waiting", {30'd0, req_valid, io_done}, 32'd0);
    end
    rsp_valid = 1'b1; rsp_rdata = rd;
    @(posedge clk); @(negedge clk);
    rsp_valid = 1'b0;
    chk(io_done === 1'b1, "R9 completion after response", {31'd0, io_done}, 32'd1);
    if (!wr) chk(io_rdata === rd, "R9 read data returned", io_rdata, rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    shadow = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(io_done === 1'b0 && req_valid === 1'b0, "R1 reset outputs idle", {30'd0, req_valid, io_done}, 32'd0);
    addr_access(1'b0, 4'hF, 0, "R1 reset value reads zero");
    set_addr(32'hFFFF_FFFF);
    addr_access(1'b0, 4'hF, 0, "R1 readback with low bits cleared");
    addr_access(1'b1, 4'h3, 32'h1234_5678, "R2 partial write completes");
    addr_access(1'b0, 4'hF, 0, "R2 partial write left value");
    io_start(1'b1, 16'h0080, 4'hF, 32'h8000_0000);
    chk(io_done === 1'b0 && req_valid === 1'b0, "R10 other port ignored", {30'd0, req_valid, io_done}, 32'd0);
    @(negedge clk);
    chk(io_done === 1'b0 && req_valid === 1'b0, "R10 other port still ignored", {30'd0, req_valid, io_done}, 32'd0);
    addr_access(1'b0, 4'hF, 0, "R10 address unchanged by other port");
    set_addr(32'h0001_0800);
    data_access(1'b0, 4'hF, 0, 32'h0, 0);
    data_access(1'b1, 4'hF, 32'hAAAA_5555, 32'h0, 1);
    sec_bus = 8'd3; sub_bus = 8'd5;
    set_addr(32'h8000_0004); data_access(1'b0, 4'hF, 0, 32'h1111_2222, 0);
    set_addr(32'h8000_0800); data_access(1'b0, 4'hF, 0, 32'h3333_4444, 2);
    set_addr(32'h8000_2A10); data_access(1'b1, 4'h6, 32'hDEAD_BEEF, 32'h0, 1);
    set_addr(32'h8003_0000); data_access(1'b0, 4'hF, 0, 32'h5555_6666, 0);
    set_addr(32'h8005_F8FC); data_access(1'b0, 4'hF, 0, 32'h7777_8888, 3);
    set_addr(32'h8006_0000); data_access(1'b0, 4'hF, 0, 32'h9999_AAAA, 0);
    set_addr(32'h8002_0000); data_access(1'b1, 4'hF, 32'h0BAD_F00D, 32'h0, 0);
    sec_bus = 8'd7; sub_bus = 8'd2;
    set_addr(32'h8004_0000); data_access(1'b0, 4'hF, 0, 32'hCAFE_0001, 1);
    set_addr(32'h8007_0000); data_access(1'b0, 4'hF, 0, 32'hCAFE_0002, 0);
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      sec_bus = 8'($urandom_range(0, 6));
      sub_bus = 8'($urandom_range(0, 8));
      a = $urandom;
      a[23:16] = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(0, 10));
      if ($urandom_range(0, 2) == 0) a[15:11] = 5'($urandom_range(0, 2));
      a[31] = ($urandom_range(0, 7) != 0);
      set_addr(a);
      data_access(1'($urandom), 4'($urandom), $urandom, $urandom, $urandom_range(0, 3));
    end
    addr_access(1'b0, 4'hF, 0, "R1 final readback");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule